// File: doc/BRIEF.md
# NAND Page Layout Interleaver

This block walks the physical byte order of one NAND page and tags every byte with where it belongs in the logical view. The logical view has two buffers: a contiguous data buffer and a spare buffer. In the physical order, a short metadata field comes first. Data packets and their ECC bytes then alternate. A six-byte bad-block-marker window sits at the page-size offset and cuts the final packet in two.

The block has two modes, and the mode is chosen at start. In scatter mode, a physical-order byte stream enters and leaves unchanged. Each output byte carries a target flag (data or spare) and a logical offset, so a downstream writer can place it. In gather mode no input is consumed. The block emits only the tag and offset sequence in physical order, which a reader uses as fetch addresses to assemble the physical page from the two buffers.

Page size, packet size and ECC strength are run-time inputs. They are captured on the start pulse. The ECC byte count per packet is derived from the strength.

Top module: `nand_page_lay`

## Requirements
- R1: After reset, and whenever no page is in progress, out_valid_o, in_ready_o and done_o are low.
- R2: The first four physical bytes of a page go to spare offsets 6, 7, 8 and 9, in that order.
- R3: A packet's data bytes are tagged data (out_spare_o=0). Their logical offsets continue without gaps from the previous packet, starting at 0 for the page.
  - Before the first packet the remaining count is the full page size.
  - After each packet it is the page size minus the physical bytes emitted so far.
  - A full packet is emitted while that count exceeds the packet size.
- R4: Each full packet is followed by its ECC bytes, tagged spare (out_spare_o=1).
  - The number of ECC bytes is ceil(strength*15/8).
  - The ECC bytes of packet i occupy spare offsets 10+i*ecc onward.
- R5: The last packet is emitted in split form, in this order:
  - a head of data bytes equal to the remaining count (none if it is zero);
  - six marker bytes at spare offsets 0 to 5;
  - the rest of the packet as data;
  - that packet's ECC bytes.
- R6: done_o pulses high for exactly one cycle, in the cycle after the final ECC byte is accepted. The block is then idle.
- R7: A byte transfers only when out_valid_o and out_ready_i are both high. While out_ready_i is low, the tag and offset hold steady.
- R8: In scatter mode, out_byte_o equals in_byte_i. in_ready_o is high only when out_ready_i is high. The output is valid exactly when in_valid_i is high during a page.
- R9: In gather mode, in_ready_o stays low, out_byte_o is zero, and tags and offsets are emitted without any input.
- R10: Page size, packet size, strength and mode are sampled only on start_i. Changing them mid-page has no effect on the sequence.
- R11: A start_i pulse during a page restarts the walk at physical position zero.
- R12: Strength must be at least 1. The page size must be a whole multiple of the packet size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page walk, sampling the configuration |
| gather_i | input | 1 | 1 = gather (address only), 0 = scatter (pass bytes) |
| page_bytes_i | input | PW | Page size in bytes |
| pkt_bytes_i | input | PW | Packet size in bytes |
| strength_i | input | STW | ECC strength in correctable bits |
| in_valid_i | input | 1 | Physical byte available (scatter mode) |
| in_ready_o | output | 1 | Physical byte accepted |
| in_byte_i | input | 8 | Physical byte |
| out_valid_o | output | 1 | Tagged beat available |
| out_ready_i | input | 1 | Tagged beat taken |
| out_byte_o | output | 8 | Byte value (zero in gather mode) |
| out_spare_o | output | 1 | 1 = spare buffer, 0 = data buffer |
| out_off_o | output | PW | Logical offset in the chosen buffer |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench keeps the default widths (16-bit offsets, 6-bit strength) and varies the run-time configuration.

- A 32-byte page of 8-byte packets at strength 2 gives two full packets and a four-plus-four split around the marker.
- A 64-byte page of 16-byte packets at strength 4 gives a twelve-plus-four split, walked in gather mode under back-pressure.
- Two more configurations cover the boundary cases:
  - a remaining count exactly equal to the packet size, which leaves an empty tail;
  - a single-packet page, where the first remaining count is the whole page.

// File: rtl/nand_lay_pkg.sv
package nand_lay_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_META, ST_DATA, ST_ECC, ST_HEAD, ST_BBM, ST_TAIL, ST_LECC
  } lay_state_e;

  localparam int META_BYTES     = 4;
  localparam int MARK_BYTES     = 6;
  localparam int META_SPARE_OFF = 6;
  localparam int ECC_SPARE_OFF  = 10;
  localparam int FIELD_BITS     = 15;
endpackage

// File: rtl/nand_lay_cfg.sv
module nand_lay_cfg #(
  parameter int PW  = 16,
  parameter int STW = 6,
  localparam int EW = STW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          gather_i,
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] pkt_i,
  input  logic [STW-1:0] strength_i,
  output logic          gather_o,
  output logic [PW-1:0] page_o,
  output logic [PW-1:0] pkt_o,
  output logic [EW-1:0] ecc_o
);
  import nand_lay_pkg::*;

  localparam int PRW = STW + 5;

  logic [PRW-1:0] prod;
  always_comb begin
    prod = PRW'(strength_i) * PRW'(FIELD_BITS) + PRW'(7);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gather_o <= 1'b0;
      page_o   <= '0;
      pkt_o    <= '0;
      ecc_o    <= '0;
    end else if (start_i) begin
      gather_o <= gather_i;
      page_o   <= page_i;
      pkt_o    <= pkt_i;
      ecc_o    <= prod[EW+2:3];
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(page_o) && $stable(pkt_o) && $stable(ecc_o) && $stable(gather_o));
endmodule

// File: rtl/nand_lay_seq.sv
module nand_lay_seq #(
  parameter int PW = 16,
  parameter int EW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] pkt_i,
  input  logic [EW-1:0] ecc_i,
  output logic          busy_o,
  output logic          spare_o,
  output logic [PW-1:0] off_o,
  output logic          done_o
);
  import nand_lay_pkg::*;

  lay_state_e    state_q;
  logic [PW-1:0] cnt_q, len_q, doff_q, eptr_q, tail_q;
  logic [PW:0]   pos_q;
  logic          done_q;

  logic          last;
  logic [PW+1:0] rem;
  logic          rem_neg, rem_big, rem_pos;
  logic [PW-1:0] ecc_len;

  assign ecc_len = PW'(ecc_i);
  assign last    = (cnt_q == len_q - 1'b1);

  always_comb begin
    // first decision uses the whole page, later ones the distance to it
    if (state_q == ST_META) rem = {2'b00, page_i};
    else                    rem = {2'b00, page_i} - {1'b0, pos_q + 1'b1};
    rem_neg = rem[PW+1];
    rem_big = !rem_neg && (rem > {2'b00, pkt_i});
    rem_pos = !rem_neg && (rem != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      doff_q  <= '0;
      eptr_q  <= '0;
      tail_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_META;
        cnt_q   <= '0;
        len_q   <= PW'(META_BYTES);
        pos_q   <= '0;
        doff_q  <= '0;
        eptr_q  <= PW'(ECC_SPARE_OFF);
        tail_q  <= '0;
      end else if (adv_i && state_q != ST_IDLE) begin
        pos_q <= pos_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
        if (state_q inside {ST_DATA, ST_HEAD, ST_TAIL}) doff_q <= doff_q + 1'b1;
        if (state_q inside {ST_ECC, ST_LECC})           eptr_q <= eptr_q + 1'b1;
        if (last) begin
          cnt_q <= '0;
          unique case (state_q)
            ST_META, ST_ECC: begin
              if (rem_big) begin
                state_q <= ST_DATA;
                len_q   <= pkt_i;
              end else if (rem_pos) begin
                state_q <= ST_HEAD;
                len_q   <= rem[PW-1:0];
                tail_q  <= pkt_i - rem[PW-1:0];
              end else begin
                state_q <= ST_BBM;
                len_q   <= PW'(MARK_BYTES);
                tail_q  <= pkt_i;
              end
            end
            ST_DATA: begin
              state_q <= ST_ECC;
              len_q   <= ecc_len;
            end
            ST_HEAD: begin
              state_q <= ST_BBM;
              len_q   <= PW'(MARK_BYTES);
            end
            ST_BBM: begin
              if (tail_q != '0) begin
                state_q <= ST_TAIL;
                len_q   <= tail_q;
              end else begin
                state_q <= ST_LECC;
                len_q   <= ecc_len;
              end
            end
            ST_TAIL: begin
              state_q <= ST_LECC;
              len_q   <= ecc_len;
            end
            ST_LECC: begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    spare_o = 1'b1;
    off_o   = '0;
    unique case (state_q)
      ST_META:                   off_o = PW'(META_SPARE_OFF) + cnt_q;
      ST_DATA, ST_HEAD, ST_TAIL: begin spare_o = 1'b0; off_o = doff_q; end
      ST_ECC, ST_LECC:           off_o = eptr_q;
      ST_BBM:                    off_o = cnt_q;
      default:                   spare_o = 1'b0;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  p_meta_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_META |-> spare_o && off_o >= PW'(META_SPARE_OFF) && off_o < PW'(ECC_SPARE_OFF));
  p_ecc_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_ECC, ST_LECC} |-> spare_o && off_o >= PW'(ECC_SPARE_OFF));
  p_marker_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BBM |-> spare_o && off_o < PW'(MARK_BYTES));
  p_data_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !start_i && !spare_o && busy_o |=> doff_q == $past(doff_q) + 1'b1);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pos_q == '0 && state_q == ST_META);
endmodule

// File: rtl/nand_page_lay.sv
module nand_page_lay #(
  parameter int PW  = 16,
  parameter int STW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           gather_i,
  input  logic [PW-1:0]  page_bytes_i,
  input  logic [PW-1:0]  pkt_bytes_i,
  input  logic [STW-1:0] strength_i,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [7:0]     in_byte_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [7:0]     out_byte_o,
  output logic           out_spare_o,
  output logic [PW-1:0]  out_off_o,
  output logic           done_o
);
  localparam int EW = STW + 1;

  logic          gather_q, busy, adv;
  logic [PW-1:0] page_q, pkt_q;
  logic [EW-1:0] ecc_q;

  nand_lay_cfg #(.PW(PW), .STW(STW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .gather_i   (gather_i),
    .page_i     (page_bytes_i),
    .pkt_i      (pkt_bytes_i),
    .strength_i (strength_i),
    .gather_o   (gather_q),
    .page_o     (page_q),
    .pkt_o      (pkt_q),
    .ecc_o      (ecc_q)
  );

  nand_lay_seq #(.PW(PW), .EW(EW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv),
    .page_i  (page_q),
    .pkt_i   (pkt_q),
    .ecc_i   (ecc_q),
    .busy_o  (busy),
    .spare_o (out_spare_o),
    .off_o   (out_off_o),
    .done_o  (done_o)
  );

  assign out_valid_o = busy && (gather_q || in_valid_i);
  assign in_ready_o  = busy && !gather_q && out_ready_i;
  assign out_byte_o  = gather_q ? 8'h00 : in_byte_i;
  assign adv         = out_valid_o && out_ready_i;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !out_valid_o && !in_ready_o);
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !start_i |=> $stable(out_spare_o) && $stable(out_off_o));
  p_ready_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i && !gather_q);
  p_gather_no_input_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gather_q |-> !in_ready_o && out_byte_o == 8'h00);
endmodule

// File: tb/nand_page_lay_test.sv
module nand_page_lay_test;
  localparam int PW  = 16;
  localparam int STW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0, gather = 1'b0;
  logic [PW-1:0]  page = '0, pkt = '0;
  logic [STW-1:0] strength = '0;
  logic           in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [7:0]     in_byte = '0, out_byte;
  logic           out_spare, done;
  logic [PW-1:0]  out_off;

  int checks = 0, fails = 0;
  int exp_spare [0:511];
  int exp_off   [0:511];
  int exp_tag   [0:511];
  int exp_n;

  always #2 clk = ~clk;

  nand_page_lay #(.PW(PW), .STW(STW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gather_i(gather),
    .page_bytes_i(page), .pkt_bytes_i(pkt), .strength_i(strength),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_byte_i(in_byte),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_byte_o(out_byte),
    .out_spare_o(out_spare), .out_off_o(out_off), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int sp, input int off, input int tag);
    exp_spare[exp_n] = sp; exp_off[exp_n] = off; exp_tag[exp_n] = tag; exp_n++;
  endtask

  // reference walk written from R2..R5: tag 2 meta, 3 data, 4 ecc, 5 split/marker
  task automatic build_ref(input int pg, input int pk, input int st);
    int ecc = (st * 15 + 7) / 8;
    int pos = 0, d = 0, e = 10, rem = pg, head, tail;
    exp_n = 0;
    for (int i = 0; i < 4; i++) begin push(1, 6 + i, 2); pos++; end
    while (rem > pk) begin
      for (int i = 0; i < pk; i++) begin push(0, d, 3); d++; pos++; end
      for (int i = 0; i < ecc; i++) begin push(1, e, 4); e++; pos++; end
      rem = pg - pos;
    end
    head = (rem > 0) ? rem : 0;
    tail = pk - head;
    for (int i = 0; i < head; i++) begin push(0, d, 5); d++; end
    for (int i = 0; i < 6; i++) push(1, i, 5);
    for (int i = 0; i < tail; i++) begin push(0, d, 5); d++; end
    for (int i = 0; i < ecc; i++) begin push(1, e, 5); e++; end
  endtask

  task automatic tag_name(input int t, output string s);
    case (t)
      2: s = "R2"; 3: s = "R3"; 4: s = "R4"; default: s = "R5";
    endcase
  endtask

  // one page walk; pg2/pk2/st2 are applied right after start (R10)
  task automatic run_page(input int pg, input int pk, input int st, input bit gth,
                          input int stall, input int pg2, input int pk2, input int st2);
    int idx = 0, cyc = 0;
    bit seen_done = 0;
    string rq;
    build_ref(pg, pk, st);
    @(negedge clk);
    page = PW'(pg); pkt = PW'(pk); strength = STW'(st); gather = gth; start = 1'b1;
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    page = PW'(pg2); pkt = PW'(pk2); strength = STW'(st2); gather = !gth;
    while (!seen_done && cyc < 2000) begin
      if (cyc != 0) @(negedge clk);
      out_ready = (stall == 0) || (cyc % stall != 1);
      in_valid  = 1'b1;
      in_byte   = 8'((idx * 7 + 3) & 8'hff);
      #1;
      if (done) begin
        seen_done = 1;
        check(idx == exp_n, "R6 count at done", idx, exp_n);
        check(!out_valid, "R6 idle at done", int'(out_valid), 0);
      end else begin
        if (gth) begin
          check(!in_ready, "R9 in_ready low", int'(in_ready), 0);
          check(out_byte == 8'h00, "R9 zero byte", int'(out_byte), 0);
        end else begin
          check(in_ready == out_ready, "R8 in_ready", int'(in_ready), int'(out_ready));
          check(out_byte == in_byte, "R8 pass byte", int'(out_byte), int'(in_byte));
        end
        if (!out_ready && idx < exp_n) begin
          // R7 stalled beat must not be lost: same entry expected next time
          check(out_valid, "R7 valid under stall", int'(out_valid), 1);
        end
        if (out_valid && out_ready) begin
          if (idx < exp_n) begin
            tag_name(exp_tag[idx], rq);
            check(int'(out_spare) == exp_spare[idx], {rq, " target"}, int'(out_spare), exp_spare[idx]);
            check(int'(out_off) == exp_off[idx], {rq, " offset"}, int'(out_off), exp_off[idx]);
          end else begin
            check(0, "R6 beat after last", idx, exp_n);
          end
          idx++;
        end
      end
      cyc++;
    end
    check(seen_done, "R6 done seen", int'(seen_done), 1);
    @(negedge clk); #1;
    check(!done, "R6 single pulse", int'(done), 0);
    check(!out_valid && !in_ready, "R1 idle after page", int'(out_valid), 0);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(!out_valid && !in_ready && !done, "R1 during reset", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && !in_ready && !done, "R1 after reset", int'(in_ready), 0);
  endtask

  task automatic t_scatter_basic;     // R2 R3 R4 R5 R8
    run_page(32, 8, 2, 1'b0, 0, 32, 8, 2);
  endtask

  task automatic t_gather_stall;      // R7 R9, split 12+4
    run_page(64, 16, 4, 1'b1, 3, 64, 16, 4);
  endtask

  task automatic t_empty_tail;        // R5 boundary: head equals packet
    run_page(32, 8, 1, 1'b0, 2, 32, 8, 1);
  endtask

  task automatic t_single_packet;     // R3 R12: first decision uses full page
    run_page(8, 8, 1, 1'b0, 0, 8, 8, 1);
  endtask

  task automatic t_cfg_change;        // R10
    run_page(32, 8, 2, 1'b0, 0, 64, 16, 5);
  endtask

  task automatic t_restart;           // R11
    @(negedge clk);
    page = 16'd64; pkt = 16'd16; strength = 6'd4; gather = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; out_ready = 1'b1; in_valid = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check(out_valid, "R11 mid-page busy", int'(out_valid), 1);
    run_page(32, 8, 2, 1'b0, 0, 32, 8, 2);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_scatter_basic();
    t_gather_stall();
    t_empty_tail();
    t_single_packet();
    t_cfg_change();
    t_restart();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule